// File: doc/BRIEF.md
# Acknowledged Packet Link Controller

This block sits between a packet sender/receiver datapath and the physical layer. It decides when a packet goes on air and what control header it carries, and it automates the exchange that confirms each packet arrived.

On the sending side, a send strobe starts a new packet with the next 3-bit sequence number. With automatic retransmit enabled, the controller then listens for a reply. If no acknowledgement arrives within the programmed wait, it sends the same packet again. This repeats until a reply arrives or the retry limit is used up. Each wait is the base delay plus a pseudo-random offset, so two colliding senders drift apart. On the receiving side, a listen strobe arms the receiver. With automatic acknowledge enabled, every accepted packet is answered at once with a reply frame that carries the received sequence number and up to three bytes of user data. A repeated sequence number is recognised as a retransmission: it is acknowledged again but not handed on a second time.

Two sticky flags report the outcome and are cleared by the next accepted strobe. The success flag means a valid packet was received or an acknowledgement came back. The end flag means the retransmit process has finished. The busy output stays high for the whole exchange.

Top module: `arq_link_ctrl`

## Requirements
- R1: After reset, busy_o, valid_ok_o, resend_end_o, deliver_o, phy_tx_req_o and phy_rx_req_o are 0, retry_cnt_o is 0, and control byte 0 (ctl_bytes_o[7:0]) reads 8'h38.
- R2: Control byte 0 always has bits [7:3] = 5'b00111 and bits [2:0] = the sequence number. The transmit sequence number is incremented (mod 8) by each accepted send strobe and stays unchanged across retransmissions.
- R3: ctl_cnt_o is 0 when ctl_len_i is 0, and ctl_len_i+1 otherwise. ctl_bytes_o[31:8] carries ack_info_i, byte 1 in bits [15:8].
- R4: With resend_en_i = 0, a send strobe yields exactly one transmission, after which the block returns to idle with valid_ok_o and resend_end_o both 0.
- R5: With resend_en_i = 1, after each transmission the block holds phy_rx_req_o. If no reply arrives, it raises phy_tx_req_o again after W cycles, where (resend_dly_i+1)*TICK_DIV <= W <= (resend_dly_i+8)*TICK_DIV, counted from the clock edge that accepts phy_tx_done_i.
- R6: A packet received while waiting ends the exchange with valid_ok_o = 1 and resend_end_o = 1. retry_cnt_o then shows how many retransmissions were made.
- R7: If no reply arrives, the packet is sent 1 + retry_max_i times in total (retry_max_i from 0 to 15). The block then returns to idle with resend_end_o = 1, valid_ok_o = 0 and retry_cnt_o = retry_max_i.
- R8: In listen mode, a received packet sets valid_ok_o. With ack_en_i = 1, the block then immediately raises phy_tx_req_o for a reply whose control byte 0 carries the received sequence number.
- R9: A received packet whose byte 0 has the 5'b00111 pattern and repeats the sequence number of the previous received packet does not pulse deliver_o, but is still acknowledged. Every other received packet pulses deliver_o for one cycle.
- R10: busy_o is 1 from the cycle after an accepted strobe until the exchange ends, including all waits, retransmissions and acknowledgements. Strobes while busy are ignored.
- R11: valid_ok_o and resend_end_o are sticky and are cleared only by an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ack_en_i | input | 1 | Enable automatic acknowledge in listen mode |
| resend_en_i | input | 1 | Enable automatic retransmit after a send |
| retry_max_i | input | 4 | Maximum number of retransmissions |
| ctl_len_i | input | 2 | Control header length select |
| resend_dly_i | input | 8 | Base reply wait, in units of TICK_DIV cycles, minus one |
| seed_i | input | 8 | Seed for the random wait offset |
| ack_info_i | input | 24 | User bytes placed in control bytes 1 to 3 |
| strobe_tx_i | input | 1 | Start sending a new packet |
| strobe_rx_i | input | 1 | Start listening |
| phy_tx_done_i | input | 1 | Transmission finished |
| phy_rx_valid_i | input | 1 | Valid packet received |
| phy_rx_ctl_i | input | 8 | Control byte 0 of the received packet |
| phy_tx_req_o | output | 1 | Request a transmission (held until done) |
| phy_rx_req_o | output | 1 | Request the receiver on |
| ctl_bytes_o | output | 32 | Control bytes to send, byte 0 in bits [7:0] |
| ctl_cnt_o | output | 3 | Number of control bytes to send |
| busy_o | output | 1 | Exchange in progress |
| valid_ok_o | output | 1 | Sticky success flag |
| resend_end_o | output | 1 | Sticky retransmit-finished flag |
| retry_cnt_o | output | 4 | Retransmissions made in the current exchange |
| deliver_o | output | 1 | One-cycle pulse for a new, non-duplicate packet |

## Verification
The bench builds the block with TICK_DIV = 2 and a base delay of 3 units. This keeps every reply wait to between 8 and 22 cycles, so the exact wait window of each retransmission can be measured. It also lets full retry-exhaustion runs, and a run of nine sends that wraps the sequence number, finish in a few hundred cycles. The small delay also lets the bench place an acknowledgement inside the second wait, and retry limits of 0 and 2 cover both the no-retry edge and a multi-retry run.

// File: rtl/arq_pkg.sv
package arq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TX   = 3'd1,
    ST_WAIT = 3'd2,
    ST_RX   = 3'd3,
    ST_ACK  = 3'd4
  } arq_state_e;

  localparam logic [4:0] CTL_MARK = 5'b00111;
endpackage

// File: rtl/arq_lfsr.sv
module arq_lfsr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic         fb;

  // taps for the 8-bit maximal polynomial; other widths fold the same positions
  assign fb = q[W-1] ^ q[W-3] ^ q[W-4] ^ q[W-5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= {{(W-1){1'b0}}, 1'b1};
    else if (load_i) q <= (seed_i == '0) ? {{(W-1){1'b0}}, 1'b1} : seed_i;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  assign q_o = q;
endmodule

// File: rtl/arq_wait_timer.sv
module arq_wait_timer #(
  parameter int TICK_DIV = 16,
  parameter int UNIT_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [UNIT_W-1:0] units_i,
  input  logic              stop_i,
  output logic              expired_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic              run;
  logic [UNIT_W-1:0] units;
  logic [PRE_W-1:0]  pre;

  assign expired_o = run && (units == UNIT_W'(1)) && (pre == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run   <= 1'b0;
      units <= '0;
      pre   <= '0;
    end else if (load_i) begin
      run   <= 1'b1;
      units <= units_i;
      pre   <= PRE_MAX;
    end else if (stop_i || expired_o) begin
      run   <= 1'b0;
    end else if (run) begin
      if (pre == '0) begin
        pre   <= PRE_MAX;
        units <= units - UNIT_W'(1);
      end else begin
        pre   <= pre - PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/arq_ctl_builder.sv
module arq_ctl_builder
  import arq_pkg::*;
#(
  parameter int SEQ_W = 3
) (
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [1:0]       len_i,
  input  logic [23:0]      info_i,
  output logic [31:0]      bytes_o,
  output logic [2:0]       cnt_o
);
  assign bytes_o = {info_i, CTL_MARK, seq_i};
  assign cnt_o   = (len_i == 2'd0) ? 3'd0 : ({1'b0, len_i} + 3'd1);
endmodule

// File: rtl/arq_link_ctrl.sv
module arq_link_ctrl
  import arq_pkg::*;
#(
  parameter int TICK_DIV = 16,
  parameter int SEQ_W    = 3,
  parameter int RETRY_W  = 4,
  parameter int DLY_W    = 8,
  parameter int SEED_W   = 8,
  parameter int OFF_W    = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ack_en_i,
  input  logic         resend_en_i,
  input  logic [3:0]   retry_max_i,
  input  logic [1:0]   ctl_len_i,
  input  logic [7:0]   resend_dly_i,
  input  logic [7:0]   seed_i,
  input  logic [23:0]  ack_info_i,
  input  logic         strobe_tx_i,
  input  logic         strobe_rx_i,
  input  logic         phy_tx_done_i,
  input  logic         phy_rx_valid_i,
  input  logic [7:0]   phy_rx_ctl_i,
  output logic         phy_tx_req_o,
  output logic         phy_rx_req_o,
  output logic [31:0]  ctl_bytes_o,
  output logic [2:0]   ctl_cnt_o,
  output logic         busy_o,
  output logic         valid_ok_o,
  output logic         resend_end_o,
  output logic [3:0]   retry_cnt_o,
  output logic         deliver_o
);
  localparam int UNIT_W = DLY_W + 2;

  arq_state_e         state_q;
  logic [SEQ_W-1:0]   tx_seq_q, rx_seq_q, hdr_seq;
  logic               have_rx_q;
  logic [RETRY_W-1:0] retry_q;
  logic               valid_q, end_q, deliver_q;
  logic [SEED_W-1:0]  lfsr_q;
  logic [UNIT_W-1:0]  wait_units;
  logic               start_tx, start_rx, tmr_load, tmr_exp, rx_dup;

  assign start_tx = (state_q == ST_IDLE) && strobe_tx_i;
  assign start_rx = (state_q == ST_IDLE) && strobe_rx_i && !strobe_tx_i;
  assign tmr_load = (state_q == ST_TX) && phy_tx_done_i && resend_en_i;
  assign rx_dup   = have_rx_q && (phy_rx_ctl_i[7:3] == CTL_MARK)
                    && (phy_rx_ctl_i[SEQ_W-1:0] == rx_seq_q);
  assign wait_units = UNIT_W'(resend_dly_i) + UNIT_W'(1) + UNIT_W'(lfsr_q[OFF_W-1:0]);

  arq_lfsr #(.W(SEED_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_tx),
    .seed_i (seed_i),
    .step_i (tmr_load),
    .q_o    (lfsr_q)
  );

  arq_wait_timer #(.TICK_DIV(TICK_DIV), .UNIT_W(UNIT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .units_i   (wait_units),
    .stop_i    (state_q != ST_WAIT),
    .expired_o (tmr_exp)
  );

  assign hdr_seq = (state_q == ST_ACK) ? rx_seq_q : tx_seq_q;

  arq_ctl_builder #(.SEQ_W(SEQ_W)) u_ctl (
    .seq_i   (hdr_seq),
    .len_i   (ctl_len_i),
    .info_i  (ack_info_i),
    .bytes_o (ctl_bytes_o),
    .cnt_o   (ctl_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_seq_q  <= '0;
      rx_seq_q  <= '0;
      have_rx_q <= 1'b0;
      retry_q   <= '0;
      valid_q   <= 1'b0;
      end_q     <= 1'b0;
      deliver_q <= 1'b0;
    end else begin
      deliver_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_tx) begin
            state_q  <= ST_TX;
            tx_seq_q <= tx_seq_q + SEQ_W'(1);
            retry_q  <= '0;
            valid_q  <= 1'b0;
            end_q    <= 1'b0;
          end else if (start_rx) begin
            state_q  <= ST_RX;
            valid_q  <= 1'b0;
            end_q    <= 1'b0;
          end
        end
        ST_TX: begin
          if (phy_tx_done_i) state_q <= resend_en_i ? ST_WAIT : ST_IDLE;
        end
        ST_WAIT: begin
          if (phy_rx_valid_i) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
            end_q   <= 1'b1;
          end else if (tmr_exp) begin
            if (retry_q == RETRY_W'(retry_max_i)) begin
              state_q <= ST_IDLE;
              end_q   <= 1'b1;
            end else begin
              state_q <= ST_TX;
              retry_q <= retry_q + RETRY_W'(1);
            end
          end
        end
        ST_RX: begin
          if (phy_rx_valid_i) begin
            valid_q   <= 1'b1;
            deliver_q <= !rx_dup;
            rx_seq_q  <= phy_rx_ctl_i[SEQ_W-1:0];
            have_rx_q <= 1'b1;
            state_q   <= ack_en_i ? ST_ACK : ST_IDLE;
          end
        end
        ST_ACK: begin
          if (phy_tx_done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phy_tx_req_o = (state_q == ST_TX) || (state_q == ST_ACK);
  assign phy_rx_req_o = (state_q == ST_WAIT) || (state_q == ST_RX);
  assign busy_o       = (state_q != ST_IDLE);
  assign valid_ok_o   = valid_q;
  assign resend_end_o = end_q;
  assign retry_cnt_o  = 4'(retry_q);
  assign deliver_o    = deliver_q;
endmodule

// File: rtl/arq_link_ctrl_chk.sv
module arq_link_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_en_i,
  input logic        resend_en_i,
  input logic [3:0]  retry_max_i,
  input logic [1:0]  ctl_len_i,
  input logic [7:0]  resend_dly_i,
  input logic [7:0]  seed_i,
  input logic [23:0] ack_info_i,
  input logic        strobe_tx_i,
  input logic        strobe_rx_i,
  input logic        phy_tx_done_i,
  input logic        phy_rx_valid_i,
  input logic [7:0]  phy_rx_ctl_i,
  input logic        phy_tx_req_o,
  input logic        phy_rx_req_o,
  input logic [31:0] ctl_bytes_o,
  input logic [2:0]  ctl_cnt_o,
  input logic        busy_o,
  input logic        valid_ok_o,
  input logic        resend_end_o,
  input logic [3:0]  retry_cnt_o,
  input logic        deliver_o
);
  assert_hdr_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_bytes_o[7:3] == 5'b00111);

  assert_busy_cover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_tx_req_o || phy_rx_req_o) |-> busy_o);

  assert_req_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phy_tx_req_o && phy_rx_req_o));

  assert_retry_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (retry_cnt_o <= retry_max_i));

  assert_end_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resend_end_o) |-> !busy_o);

  assert_valid_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_ok_o) |-> $past(strobe_tx_i || strobe_rx_i));

  assert_end_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resend_end_o) |-> $past(strobe_tx_i || strobe_rx_i));

  assert_deliver_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> valid_ok_o);
endmodule

bind arq_link_ctrl arq_link_ctrl_chk u_chk (.*);

// File: tb/arq_link_ctrl_test.sv
module arq_link_ctrl_test;
  localparam int TD  = 2;
  localparam int DLY = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ack_en_i = 1'b0, resend_en_i = 1'b0;
  logic [3:0]  retry_max_i = 4'd0;
  logic [1:0]  ctl_len_i = 2'd0;
  logic [7:0]  resend_dly_i = 8'(DLY);
  logic [7:0]  seed_i = 8'h5B;
  logic [23:0] ack_info_i = 24'hC0FFEE;
  logic        strobe_tx_i = 1'b0, strobe_rx_i = 1'b0;
  logic        phy_tx_done_i = 1'b0, phy_rx_valid_i = 1'b0;
  logic [7:0]  phy_rx_ctl_i = 8'h00;
  logic        phy_tx_req_o, phy_rx_req_o, busy_o, valid_ok_o, resend_end_o, deliver_o;
  logic [31:0] ctl_bytes_o;
  logic [2:0]  ctl_cnt_o;
  logic [3:0]  retry_cnt_o;

  int checks = 0, failures = 0;
  logic [2:0] exp_seq = 3'd0;

  always #10 clk_i = ~clk_i;

  arq_link_ctrl #(.TICK_DIV(TD)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit tx);
    if (tx) strobe_tx_i = 1'b1; else strobe_rx_i = 1'b1;
    @(negedge clk_i);
    strobe_tx_i = 1'b0; strobe_rx_i = 1'b0;
  endtask

  task automatic wait_tx(output int n, input int lim);
    n = 0;
    while (!phy_tx_req_o && n < lim) begin @(negedge clk_i); n++; end
  endtask

  task automatic tx_done();
    phy_tx_done_i = 1'b1; @(negedge clk_i); phy_tx_done_i = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy_o && n < lim) begin @(negedge clk_i); n++; end
  endtask

  task automatic t_reset();
    chk(!busy_o && !valid_ok_o && !resend_end_o && !deliver_o, "R1 flags", busy_o, 0);
    chk(!phy_tx_req_o && !phy_rx_req_o && retry_cnt_o == 0, "R1 reqs", retry_cnt_o, 0);
    chk(ctl_bytes_o[7:0] == 8'h38, "R1 hdr", ctl_bytes_o[7:0], 8'h38);
  endtask

  task automatic t_plain();
    int n;
    resend_en_i = 1'b0;
    strobe(1'b1); exp_seq++;
    chk(busy_o && phy_tx_req_o, "R10 busy on send", busy_o, 1);
    chk(ctl_bytes_o[7:0] == {5'b00111, exp_seq}, "R2 seq", ctl_bytes_o[7:0], {5'b00111, exp_seq});
    tx_done();
    chk(!busy_o && !valid_ok_o && !resend_end_o, "R4 single send", busy_o, 0);
    wait_tx(n, 10);
    chk(!phy_tx_req_o, "R4 no resend", phy_tx_req_o, 0);
  endtask

  task automatic t_ack_second();
    int n;
    resend_en_i = 1'b1; retry_max_i = 4'd5;
    strobe(1'b1); exp_seq++;
    tx_done();
    chk(phy_rx_req_o && busy_o, "R5 listen after send", phy_rx_req_o, 1);
    wait_tx(n, 100);
    chk(n >= (DLY+1)*TD && n <= (DLY+8)*TD, "R5 wait window", n, (DLY+1)*TD);
    chk(ctl_bytes_o[7:0] == {5'b00111, exp_seq}, "R2 same seq on resend", ctl_bytes_o[7:0], {5'b00111, exp_seq});
    tx_done();
    repeat (3) @(negedge clk_i);
    chk(busy_o && phy_rx_req_o, "R10 busy across resend", busy_o, 1);
    phy_rx_valid_i = 1'b1; @(negedge clk_i); phy_rx_valid_i = 1'b0;
    chk(!busy_o && valid_ok_o && resend_end_o, "R6 ack ok", {valid_ok_o, resend_end_o}, 3);
    chk(retry_cnt_o == 1, "R6 retry count", retry_cnt_o, 1);
    repeat (3) @(negedge clk_i);
    chk(valid_ok_o && resend_end_o, "R11 sticky", {valid_ok_o, resend_end_o}, 3);
  endtask

  task automatic t_exhaust(input logic [3:0] mx);
    int n, sends;
    resend_en_i = 1'b1; retry_max_i = mx;
    strobe(1'b1); exp_seq++;
    chk(!valid_ok_o && !resend_end_o, "R11 cleared by strobe", valid_ok_o, 0);
    sends = 0;
    while (busy_o && sends < 20) begin
      wait_tx(n, (DLY+10)*TD);
      if (phy_tx_req_o) begin sends++; tx_done(); end
    end
    chk(sends == int'(mx) + 1, "R7 send count", sends, int'(mx) + 1);
    chk(resend_end_o && !valid_ok_o, "R7 end flags", {valid_ok_o, resend_end_o}, 1);
    chk(retry_cnt_o == mx, "R7 retry count", retry_cnt_o, mx);
  endtask

  task automatic t_rx(input logic [7:0] hdr, input bit ack, input bit exp_del);
    ack_en_i = ack; ctl_len_i = 2'd3;
    strobe(1'b0);
    chk(phy_rx_req_o && busy_o && !valid_ok_o, "R8 listening", phy_rx_req_o, 1);
    phy_rx_ctl_i = hdr; phy_rx_valid_i = 1'b1; @(negedge clk_i); phy_rx_valid_i = 1'b0;
    chk(deliver_o == exp_del, "R9 deliver", deliver_o, exp_del);
    chk(valid_ok_o, "R8 valid", valid_ok_o, 1);
    chk(phy_tx_req_o == ack, "R8 ack send", phy_tx_req_o, ack);
    if (ack) begin
      chk(ctl_bytes_o[7:0] == {5'b00111, hdr[2:0]}, "R8 ack seq", ctl_bytes_o[7:0], {5'b00111, hdr[2:0]});
      chk(ctl_cnt_o == 3'd4 && ctl_bytes_o[31:8] == ack_info_i, "R3 ack bytes", ctl_cnt_o, 4);
      tx_done();
    end
    chk(!busy_o, "R10 idle after rx", busy_o, 0);
    @(negedge clk_i);
    chk(!deliver_o, "R9 pulse width", deliver_o, 0);
  endtask

  task automatic t_len();
    ctl_len_i = 2'd0; @(negedge clk_i);
    chk(ctl_cnt_o == 0, "R3 len0", ctl_cnt_o, 0);
    ctl_len_i = 2'd1; @(negedge clk_i);
    chk(ctl_cnt_o == 2, "R3 len1", ctl_cnt_o, 2);
  endtask

  task automatic t_ignore_busy();
    resend_en_i = 1'b0;
    strobe(1'b1); exp_seq++;
    strobe(1'b1);
    chk(ctl_bytes_o[7:0] == {5'b00111, exp_seq}, "R10 strobe ignored while busy", ctl_bytes_o[7:0], {5'b00111, exp_seq});
    tx_done();
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 9; i++) begin
      strobe(1'b1); exp_seq++; tx_done();
    end
    chk(ctl_bytes_o[7:0] == {5'b00111, exp_seq}, "R2 wrap", ctl_bytes_o[7:0], {5'b00111, exp_seq});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain();
    t_ack_second();
    t_exhaust(4'd2);
    t_exhaust(4'd0);
    t_rx(8'h3C, 1'b1, 1'b1);
    t_rx(8'h3C, 1'b1, 1'b0);
    t_rx(8'h3D, 1'b0, 1'b1);
    t_rx(8'h3D, 1'b1, 1'b0);
    t_len();
    t_ignore_busy();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule